// File: doc/BRIEF.md
# Snoop Inquire Cache-Line State Updater

This block answers external inquire (snoop) cycles against a small direct-mapped tag and state store. The store keeps one of four coherence states per line. When an external strobe is seen, the block captures the snooped line address and an invalidate request in the same clock edge. It looks up the line and reports whether it hit and whether the line was dirty. It then moves a hit line to Invalid (invalidate requested) or Shared (invalidate not requested).

A dirty (Modified) line is never left without a copy in memory. Before its state changes, the block raises a writeback request carrying the line address on a valid/ready handshake. It then waits for a completion pulse and commits the new state in the following cycle. While an inquire is being handled, the block holds a busy output high and disregards further strobes.

Lines are installed through a fill port, which stands in for the normal cache fill path. The cache data storage, ordinary processor traffic and bus arbitration live elsewhere.

Top module: `snoop_inquire_updater`

## Requirements
- R1: Line states use 2-bit codes: Invalid=00, Shared=01, Exclusive=10, Modified=11. A strobe whose tag matches a line that is not Invalid is a hit. `hit`, `hit_modified` (state 11) and `found_state` appear in the cycle after the strobe edge and stay steady until the inquire completes.
- R2: A hit with the invalidate input high on the strobe edge leaves the line Invalid, whatever its state was.
- R3: A hit with the invalidate input low on the strobe edge leaves the line Shared (01).
- R4: On a Modified hit, `wb_valid` rises with `wb_line` equal to the snooped line before any state change. The state change commits only in the cycle after `wb_done`, and `inq_done` is high in that commit cycle and not before.
- R5: A snoop that misses changes no line state and raises no writeback. `found_state` reads 00.
- R6: A line whose tag matches but whose state is Invalid is handled as a miss.
- R7: `busy` is high from the cycle after an accepted strobe until the inquire completes. A strobe during that time is ignored and leaves every line state unchanged.
- R8: After reset all outputs are low and every line is Invalid.
- R9: A fill while the block is idle installs a tag and state, which later snoops then report.
- R10: Once raised, `wb_valid` stays high with `wb_line` unchanged until `wb_ready` is seen high.
- R11: `inq_done` is a single-cycle pulse that ends each inquire. For a hit that is not Modified, or for a miss, it appears in the cycle after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snoop_strobe | input | 1 | External inquire address strobe |
| snoop_line | input | TAG_W+IDX_W | Snooped line address {tag, index} |
| snoop_inv | input | 1 | Invalidate request, sampled with the strobe |
| fill_en | input | 1 | Install a line (honoured when idle) |
| fill_line | input | TAG_W+IDX_W | Line address to install |
| fill_state | input | 2 | State to install |
| wb_ready | input | 1 | Writeback request accepted |
| wb_done | input | 1 | Writeback finished |
| hit | output | 1 | Snoop hit a valid line |
| hit_modified | output | 1 | Snoop hit a Modified line |
| found_state | output | 2 | State of the hit line (00 on miss) |
| busy | output | 1 | Inquire in progress; strobes ignored |
| inq_done | output | 1 | Inquire completion pulse |
| wb_valid | output | 1 | Writeback request |
| wb_line | output | TAG_W+IDX_W | Line address to write back |

## Verification
The bench builds the block with its defaults, TAG_W=10 and IDX_W=3. That gives eight lines, so every index can be installed in each of the four states and revisited after its transition. The tag width leaves room for a wrong-tag snoop to a filled index and for a matching tag on an Invalid entry. With that shape, one table walks each state through both invalidate settings, and directed cases hold the writeback handshake open to probe stalls and strobes ignored while busy.

// File: rtl/snp_pkg.sv
// Shared types for the snoop inquire updater.
// Assumes a 2-bit coherence code; the next-state rule depends only on invalidate.
package snp_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'b00,
        LS_S = 2'b01,
        LS_E = 2'b10,
        LS_M = 2'b11
    } line_st_e;

    typedef enum logic [2:0] {
        C_IDLE,
        C_EVAL,
        C_WBREQ,
        C_WBWAIT,
        C_COMMIT
    } ctrl_st_e;

    // State a hit line takes once the inquire completes.
    function automatic line_st_e snoop_next(input logic inv);
        return inv ? LS_I : LS_S;
    endfunction

endpackage

// File: rtl/snp_tag_array.sv
// Direct-mapped tag and state store, one entry per index.
// Assumes at most one update and one fill per cycle; an update wins over a fill.
module snp_tag_array
    import snp_pkg::*;
#(
    parameter int TAG_W = 10,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output line_st_e         rd_st,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  line_st_e         fill_st,
    input  logic             upd_we,
    input  logic [IDX_W-1:0] upd_idx,
    input  line_st_e         upd_st
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [DEPTH];
    line_st_e         st_q  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        // Per-line storage: reset to Invalid, state update before fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g] <= '0;
                st_q[g]  <= LS_I;
            end else if (upd_we && upd_idx == IDX_W'(g)) begin
                st_q[g]  <= upd_st;
            end else if (fill_we && fill_idx == IDX_W'(g)) begin
                tag_q[g] <= fill_tag;
                st_q[g]  <= fill_st;
            end
        end
    end

    assign rd_tag = tag_q[rd_idx];
    assign rd_st  = st_q[rd_idx];

endmodule

// File: rtl/snp_lookup.sv
// Tag compare for one looked-up entry.
// Assumes an entry in Invalid never hits, even with a matching tag.
module snp_lookup
    import snp_pkg::*;
#(
    parameter int TAG_W = 10
) (
    input  logic [TAG_W-1:0] want_tag,
    input  logic [TAG_W-1:0] entry_tag,
    input  line_st_e         entry_st,
    output logic             look_hit,
    output logic             look_m
);
    // Hit needs a tag match on a live entry; dirty flag follows.
    always_comb begin
        look_hit = (want_tag == entry_tag) && (entry_st != LS_I);
        look_m   = look_hit && (entry_st == LS_M);
    end

endmodule

// File: rtl/snp_ctrl.sv
// Inquire sequencer: captures a snoop, reports hit status, runs the writeback
// handshake for dirty lines and issues the single state update.
// Assumes lookup results are valid in the strobe cycle.
module snp_ctrl
    import snp_pkg::*;
#(
    parameter int TAG_W = 10,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   strobe,
    input  logic [TAG_W+IDX_W-1:0] line_in,
    input  logic                   inv_in,
    input  logic                   look_hit,
    input  logic                   look_m,
    input  line_st_e               look_st,
    input  logic                   wb_ready,
    input  logic                   wb_done,
    output logic                   hit,
    output logic                   hit_modified,
    output line_st_e               found_state,
    output logic                   busy,
    output logic                   inq_done,
    output logic                   wb_valid,
    output logic [TAG_W+IDX_W-1:0] wb_line,
    output logic                   upd_we,
    output logic [IDX_W-1:0]       upd_idx,
    output line_st_e               upd_st
);
    localparam int LINE_W = TAG_W + IDX_W;

    ctrl_st_e          st_q, st_d;
    logic [LINE_W-1:0] line_q;
    logic              inv_q;
    logic              hit_q;
    logic              hitm_q;
    line_st_e          fst_q;
    logic              accept;
    logic              finish;

    assign accept = (st_q == C_IDLE) && strobe;
    assign finish = ((st_q == C_EVAL) && !hitm_q) || (st_q == C_COMMIT);

    // Next sequencer state.
    always_comb begin
        st_d = st_q;
        case (st_q)
            C_IDLE:   if (strobe)   st_d = C_EVAL;
            C_EVAL:   st_d = hitm_q ? C_WBREQ : C_IDLE;
            C_WBREQ:  if (wb_ready) st_d = C_WBWAIT;
            C_WBWAIT: if (wb_done)  st_d = C_COMMIT;
            C_COMMIT: st_d = C_IDLE;
            default:  st_d = C_IDLE;
        endcase
    end

    // Sequencer state and captured snoop context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= C_IDLE;
            line_q <= '0;
            inv_q  <= 1'b0;
            hit_q  <= 1'b0;
            hitm_q <= 1'b0;
            fst_q  <= LS_I;
        end else begin
            st_q <= st_d;
            if (accept) begin
                line_q <= line_in;
                inv_q  <= inv_in;
                hit_q  <= look_hit;
                hitm_q <= look_m;
                fst_q  <= look_hit ? look_st : LS_I;
            end else if (finish) begin
                hit_q  <= 1'b0;
                hitm_q <= 1'b0;
                fst_q  <= LS_I;
            end
        end
    end

    // Output decode and the single state update of an inquire.
    always_comb begin
        hit          = hit_q;
        hit_modified = hitm_q;
        found_state  = fst_q;
        busy         = (st_q != C_IDLE);
        inq_done     = finish;
        wb_valid     = (st_q == C_WBREQ);
        wb_line      = line_q;
        upd_we       = finish && hit_q;
        upd_idx      = line_q[IDX_W-1:0];
        upd_st       = snoop_next(inv_q);
    end

endmodule

// File: rtl/snoop_inquire_updater.sv
// Top: snoop inquire handling over a direct-mapped coherence state store.
// Assumes a line address of {tag, index}; fills are honoured only when idle
// with no strobe present.
module snoop_inquire_updater
    import snp_pkg::*;
#(
    parameter int TAG_W = 10,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   snoop_strobe,
    input  logic [TAG_W+IDX_W-1:0] snoop_line,
    input  logic                   snoop_inv,
    input  logic                   fill_en,
    input  logic [TAG_W+IDX_W-1:0] fill_line,
    input  logic [1:0]             fill_state,
    input  logic                   wb_ready,
    input  logic                   wb_done,
    output logic                   hit,
    output logic                   hit_modified,
    output logic [1:0]             found_state,
    output logic                   busy,
    output logic                   inq_done,
    output logic                   wb_valid,
    output logic [TAG_W+IDX_W-1:0] wb_line
);
    logic [TAG_W-1:0] rd_tag;
    line_st_e         rd_st;
    logic             look_hit;
    logic             look_m;
    logic             fill_ok;
    logic             upd_we;
    logic [IDX_W-1:0] upd_idx;
    line_st_e         upd_st;
    line_st_e         fstate;

    assign fill_ok     = fill_en && !busy && !snoop_strobe;
    assign found_state = fstate;

    snp_tag_array #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (snoop_line[IDX_W-1:0]),
        .rd_tag   (rd_tag),
        .rd_st    (rd_st),
        .fill_we  (fill_ok),
        .fill_idx (fill_line[IDX_W-1:0]),
        .fill_tag (fill_line[TAG_W+IDX_W-1:IDX_W]),
        .fill_st  (line_st_e'(fill_state)),
        .upd_we   (upd_we),
        .upd_idx  (upd_idx),
        .upd_st   (upd_st)
    );

    snp_lookup #(.TAG_W(TAG_W)) u_lookup (
        .want_tag  (snoop_line[TAG_W+IDX_W-1:IDX_W]),
        .entry_tag (rd_tag),
        .entry_st  (rd_st),
        .look_hit  (look_hit),
        .look_m    (look_m)
    );

    snp_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe       (snoop_strobe),
        .line_in      (snoop_line),
        .inv_in       (snoop_inv),
        .look_hit     (look_hit),
        .look_m       (look_m),
        .look_st      (rd_st),
        .wb_ready     (wb_ready),
        .wb_done      (wb_done),
        .hit          (hit),
        .hit_modified (hit_modified),
        .found_state  (fstate),
        .busy         (busy),
        .inq_done     (inq_done),
        .wb_valid     (wb_valid),
        .wb_line      (wb_line),
        .upd_we       (upd_we),
        .upd_idx      (upd_idx),
        .upd_st       (upd_st)
    );

endmodule

// File: rtl/snoop_inquire_chk.sv
// Protocol checker for snoop_inquire_updater, bound to every instance.
// Assumes the port names of the top module.
module snoop_inquire_chk #(
    parameter int LINE_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snoop_strobe,
    input logic              wb_ready,
    input logic              wb_done,
    input logic              hit,
    input logic              hit_modified,
    input logic [1:0]        found_state,
    input logic              busy,
    input logic              inq_done,
    input logic              wb_valid,
    input logic [LINE_W-1:0] wb_line
);
    // R1
    hitm_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_modified |-> hit && found_state == 2'b11);

    // R7
    hit_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> busy);

    // R7
    strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && snoop_strobe && !inq_done |=> $stable(hit) && $stable(found_state));

    // R10
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_line));

    // R4
    wb_dirty_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> hit_modified && busy);

    // R4
    commit_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inq_done && hit_modified |-> $past(wb_done));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inq_done |=> !inq_done);

endmodule

bind snoop_inquire_updater snoop_inquire_chk #(.LINE_W(TAG_W + IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .snoop_strobe (snoop_strobe),
    .wb_ready     (wb_ready),
    .wb_done      (wb_done),
    .hit          (hit),
    .hit_modified (hit_modified),
    .found_state  (found_state),
    .busy         (busy),
    .inq_done     (inq_done),
    .wb_valid     (wb_valid),
    .wb_line      (wb_line)
);

// File: tb/sim_snoop_inquire_updater.sv
`timescale 1ns/1ps
module sim_snoop_inquire_updater;
    localparam int TAG_W  = 10;
    localparam int IDX_W  = 3;
    localparam int LINE_W = TAG_W + IDX_W;
    localparam int VW     = LINE_W + 5;
    localparam int NVEC   = 13;

    localparam logic [TAG_W-1:0] TA = 10'h123, TB = 10'h2a1, TC = 10'h055,
                                 TD = 10'h3f0, TE = 10'h111, TF = 10'h0c3,
                                 TG = 10'h20f, TH = 10'h1e7, TX = 10'h3aa;

    // {line, inv, exp_hit, exp_hitm, exp_found_state}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {TA, 3'd0, 1'b0, 1'b1, 1'b0, 2'b10},  // R3 E hit, keep
        {TA, 3'd0, 1'b0, 1'b1, 1'b0, 2'b01},  // R3 now Shared
        {TA, 3'd0, 1'b1, 1'b1, 1'b0, 2'b01},  // R2 S hit, invalidate
        {TA, 3'd0, 1'b0, 1'b0, 1'b0, 2'b00},  // R2 now Invalid
        {TB, 3'd1, 1'b0, 1'b1, 1'b1, 2'b11},  // R4 M hit, to Shared
        {TB, 3'd1, 1'b0, 1'b1, 1'b0, 2'b01},  // R3 after writeback
        {TD, 3'd3, 1'b1, 1'b1, 1'b1, 2'b11},  // R4 M hit, invalidate
        {TD, 3'd3, 1'b0, 1'b0, 1'b0, 2'b00},  // R2 now Invalid
        {TX, 3'd2, 1'b1, 1'b0, 1'b0, 2'b00},  // R5 wrong tag
        {TC, 3'd2, 1'b0, 1'b1, 1'b0, 2'b01},  // R5 line untouched
        {TE, 3'd4, 1'b0, 1'b0, 1'b0, 2'b00},  // R6 Invalid entry
        {TF, 3'd5, 1'b1, 1'b1, 1'b0, 2'b10},  // R2 E hit, invalidate
        {TF, 3'd5, 1'b0, 1'b0, 1'b0, 2'b00}   // R2 now Invalid
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              snoop_strobe, snoop_inv, fill_en, wb_ready, wb_done;
    logic [LINE_W-1:0] snoop_line, fill_line;
    logic [1:0]        fill_state;
    logic              hit, hit_modified, busy, inq_done, wb_valid;
    logic [1:0]        found_state;
    logic [LINE_W-1:0] wb_line;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    snoop_inquire_updater #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .snoop_strobe(snoop_strobe),
        .snoop_line(snoop_line), .snoop_inv(snoop_inv), .fill_en(fill_en),
        .fill_line(fill_line), .fill_state(fill_state), .wb_ready(wb_ready),
        .wb_done(wb_done), .hit(hit), .hit_modified(hit_modified),
        .found_state(found_state), .busy(busy), .inq_done(inq_done),
        .wb_valid(wb_valid), .wb_line(wb_line)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [LINE_W-1:0] ln, input logic [1:0] st);
        @(negedge clk);
        fill_en = 1'b1; fill_line = ln; fill_state = st;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // One full inquire, with the writeback handshake when a dirty hit is expected.
    task automatic snoop(input logic [LINE_W-1:0] ln, input logic iv, input logic eh,
                         input logic em, input logic [1:0] es);
        @(negedge clk);
        snoop_strobe = 1'b1; snoop_line = ln; snoop_inv = iv;
        @(negedge clk);
        snoop_strobe = 1'b0;
        check("R1 hit", hit, eh);
        check("R1 hit_modified", hit_modified, em);
        check("R1 found_state", found_state, es);
        check("R7 busy after strobe", busy, 1);
        check("R5 no early writeback", wb_valid, 0);
        if (!em) begin
            check("R11 done after strobe", inq_done, 1);
            @(negedge clk);
            check("R11 idle after done", busy, 0);
            check("R1 hit cleared", hit, 0);
        end else begin
            check("R4 not done before writeback", inq_done, 0);
            @(negedge clk);
            check("R4 wb_valid", wb_valid, 1);
            check("R4 wb_line", wb_line, ln);
            @(negedge clk);
            check("R10 wb_valid held", wb_valid, 1);
            check("R10 wb_line held", wb_line, ln);
            check("R1 hit held", hit, 1);
            wb_ready = 1'b1;
            @(negedge clk);
            wb_ready = 1'b0;
            check("R10 wb_valid drops", wb_valid, 0);
            check("R4 wait for done", inq_done, 0);
            wb_done = 1'b1;
            @(negedge clk);
            wb_done = 1'b0;
            check("R4 commit cycle after wb_done", inq_done, 1);
            check("R1 hit_modified held", hit_modified, 1);
            @(negedge clk);
            check("R11 idle after commit", busy, 0);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; snoop_strobe = 1'b0; snoop_inv = 1'b0; fill_en = 1'b0;
        wb_ready = 1'b0; wb_done = 1'b0; snoop_line = '0; fill_line = '0;
        fill_state = 2'b00;
        repeat (3) @(negedge clk);
        check("R8 hit reset", hit, 0);
        check("R8 busy reset", busy, 0);
        check("R8 wb_valid reset", wb_valid, 0);
        check("R8 done reset", inq_done, 0);
        rst_n = 1'b1;

        // R8: every line Invalid after reset, tag 0 included
        snoop({10'h000, 3'd0}, 1'b0, 1'b0, 1'b0, 2'b00);
        snoop({TA, 3'd0}, 1'b0, 1'b0, 1'b0, 2'b00);

        // R9: install lines
        fill({TA, 3'd0}, 2'b10);
        fill({TB, 3'd1}, 2'b11);
        fill({TC, 3'd2}, 2'b01);
        fill({TD, 3'd3}, 2'b11);
        fill({TE, 3'd4}, 2'b00);
        fill({TF, 3'd5}, 2'b10);
        fill({TG, 3'd6}, 2'b11);
        fill({TH, 3'd7}, 2'b10);

        for (int i = 0; i < NVEC; i++) begin
            snoop(VEC[i][VW-1:5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0]);
        end

        // R7: strobe during a writeback is ignored; R4: stall on wb_done
        @(negedge clk);
        snoop_strobe = 1'b1; snoop_line = {TG, 3'd6}; snoop_inv = 1'b1;
        @(negedge clk);
        snoop_strobe = 1'b0;
        check("R1 dirty hit", hit_modified, 1);
        @(negedge clk);
        snoop_strobe = 1'b1; snoop_line = {TH, 3'd7}; snoop_inv = 1'b1;
        wb_ready = 1'b1;
        @(negedge clk);
        snoop_strobe = 1'b0; wb_ready = 1'b0;
        check("R7 ignored strobe keeps found_state", found_state, 2'b11);
        check("R7 ignored strobe keeps line", wb_line, {TG, 3'd6});
        check("R7 busy during writeback", busy, 1);
        repeat (3) @(negedge clk);
        check("R4 no commit without wb_done", inq_done, 0);
        check("R7 busy while waiting", busy, 1);
        wb_done = 1'b1;
        @(negedge clk);
        wb_done = 1'b0;
        check("R4 commit after stall", inq_done, 1);
        @(negedge clk);
        check("R7 idle again", busy, 0);
        snoop({TG, 3'd6}, 1'b0, 1'b0, 1'b0, 2'b00);   // R2 dirty line invalidated
        snoop({TH, 3'd7}, 1'b0, 1'b1, 1'b0, 2'b10);   // R7 ignored strobe changed nothing

        // R9: refill an index with a new tag
        fill({TX, 3'd0}, 2'b01);
        snoop({TX, 3'd0}, 1'b0, 1'b1, 1'b0, 2'b01);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule